// File: doc/BRIEF.md
# Interrupt Acceptance and Mode Controller

This block decides how an 8-bit processor core responds to interrupt requests. It holds the two interrupt-enable flops (a live enable and a saved copy), a two-bit interrupt mode and an 8-bit vector base. Each cycle it looks at the non-maskable request, the maskable request with the byte on the data bus, and the decoded instruction strobes that change the enables, the mode and the vector base. When a request is taken, it issues a one-cycle response descriptor: what kind of response it is, the target address, whether the program counter has to be pushed, whether the bus byte is to be run as an opcode-fetch cycle, and the cycle cost.

The core's sequencer uses the descriptor to push the return address, load the program counter, or hand the bus byte to the decoder. The stack memory, the opcode fetch and the instruction decoder are outside this block. Two resets are provided. The cold reset initialises everything. The warm reset clears only the enables and any response in flight.

Top module: `irq_accept_ctrl`

## Requirements
- R1: Cold reset clears both enables, sets the mode to 0 and the vector base to 0xFF, and drives no response. Warm reset clears both enables and the response but keeps the mode and the vector base.
- R2: The disable strobe clears both enables and the enable strobe sets both. The new values are visible on the enable outputs one cycle after the strobe.
- R3: A maskable request while the live enable is clear is ignored. The response kind stays 0 (none), valid stays low, the cycle count stays 0 and the enables do not change.
- R4: An accepted maskable request clears both enables.
- R5: Mode 0 acceptance gives kind 1 (run opcode) with the opcode-fetch flag high. The target is {0x00, bus byte}, there is no push and the cycle count is 0, because the executed opcode carries the cost.
- R6: Mode 1 acceptance gives kind 2 (restart) with target 0x0038, push high and a cycle count of 13.
- R7: Mode 2 acceptance gives kind 3 (vectored) with target {vector base, bus byte}, push high and a cycle count of 19.
- R8: A non-maskable request is taken whatever the enables hold. It clears only the live enable and keeps the saved one. It gives kind 2 with target 0x0066, push high and a cycle count of 13.
- R9: When non-maskable and maskable requests arrive in the same cycle, the non-maskable one wins and the maskable one is not taken in that cycle.
- R10: The return-from-interrupt strobe copies the saved enable into the live enable and leaves the saved enable unchanged.
- R11: The mode-select strobe decodes a 3-bit field. Values 0, 1, 4 and 5 select mode 0, values 2 and 6 select mode 1, and values 3 and 7 select mode 2.
- R12: The vector-base load strobe sets the vector base. An acceptance in the same cycle still uses the previous base.
- R13: A response lasts exactly one cycle, with push as a one-cycle strobe. No request is taken in the cycle the response is shown; a request still held then is considered the next cycle.
- R14: Disable, enable and return strobes that arrive in the same cycle as an acceptance are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| coldRstN | input | 1 | Synchronous full initialisation, active low |
| warmRstN | input | 1 | Synchronous enable reset, active low |
| nmiReq | input | 1 | Non-maskable request |
| irqReq | input | 1 | Maskable request level |
| irqByte | input | 8 | Byte supplied on the data bus with the maskable request |
| diStrobe | input | 1 | Decoded disable-interrupts instruction |
| eiStrobe | input | 1 | Decoded enable-interrupts instruction |
| retnStrobe | input | 1 | Decoded return-from-interrupt instruction |
| imStrobe | input | 1 | Decoded mode-select instruction |
| imField | input | 3 | Mode field of the mode-select opcode |
| ldVecStrobe | input | 1 | Decoded load-vector-base instruction |
| ldVecData | input | 8 | New vector base value |
| respValid | output | 1 | Response descriptor valid (one cycle) |
| respKind | output | 2 | 0 none, 1 run opcode, 2 restart, 3 vectored |
| respTarget | output | 16 | Target address, or the opcode in the low byte |
| pushPc | output | 1 | Push the program counter |
| m1Exec | output | 1 | Run the bus byte as an opcode-fetch cycle |
| respCycles | output | 5 | Cycle cost of the response |
| iff1 | output | 1 | Live interrupt enable |
| iff2 | output | 1 | Saved interrupt enable |
| irqMode | output | 2 | Current interrupt mode |

## Verification
Assertions check on every cycle that push is a one-cycle pulse, that the opcode-fetch flag appears only with a run-opcode response, that an ignored maskable request produces nothing, that a non-maskable acceptance targets 0x0066, clears the live enable and keeps the saved enable, that a taken maskable request clears both enables, and that the return strobe restores the live enable.

Only the bench's scenarios can show the following:
- the mapping of all eight mode field values;
- the target built from a vector base loaded earlier, and the old base used in a same-cycle load;
- the winner when both requests arrive together, and the maskable request being taken again after the return restores the enable;
- the difference between the cold and warm resets.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  typedef enum logic [1:0] {
    RESP_NONE    = 2'd0,
    RESP_OPCODE  = 2'd1,
    RESP_RESTART = 2'd2,
    RESP_VECTOR  = 2'd3
  } respKind_t;

  typedef enum logic [1:0] {
    MODE_OPCODE = 2'd0,
    MODE_FIXED  = 2'd1,
    MODE_TABLE  = 2'd2,
    MODE_SPARE  = 2'd3
  } irqMode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic takeNmi;
    logic takeIrq;
    logic clrBoth;
    logic setBoth;
    logic restoreEn;
    logic loadMode;
    logic loadVec;
  } ctrlStrobe_t;

  // 3-bit mode field: bit1 clear -> mode 0, else bit0 picks table/fixed
  function automatic irqMode_t decodeModeField(input logic [2:0] field);
    irqMode_t m;
    if (!field[1])     m = MODE_OPCODE;
    else if (field[0]) m = MODE_TABLE;
    else               m = MODE_FIXED;
    return m;
  endfunction

endpackage

// File: rtl/irq_accept_control.sv
module irq_accept_control
  import irq_accept_pkg::*;
(
  input  logic        nmiReq,
  input  logic        irqReq,
  input  logic        liveEn,
  input  logic        busy,
  input  logic        diStrobe,
  input  logic        eiStrobe,
  input  logic        retnStrobe,
  input  logic        imStrobe,
  input  logic        ldVecStrobe,
  output ctrlStrobe_t strobes
);

  logic takeNmi;
  logic takeIrq;
  logic anyTake;

  // the response cycle blocks new acceptance; NMI outranks the maskable line
  assign takeNmi = !busy && nmiReq;
  assign takeIrq = !busy && !nmiReq && irqReq && liveEn;
  assign anyTake = takeNmi || takeIrq;

  always_comb begin
    strobes           = '0;
    strobes.takeNmi   = takeNmi;
    strobes.takeIrq   = takeIrq;
    strobes.clrBoth   = !anyTake && diStrobe;
    strobes.setBoth   = !anyTake && !diStrobe && eiStrobe;
    strobes.restoreEn = !anyTake && !diStrobe && !eiStrobe && retnStrobe;
    strobes.loadMode  = imStrobe;
    strobes.loadVec   = ldVecStrobe;
  end

endmodule

// File: rtl/irq_accept_datapath.sv
module irq_accept_datapath
  import irq_accept_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          ADDR_W     = 16,
  parameter int          CYC_W      = 5,
  parameter logic [7:0]  VEC_INIT   = 8'hFF,
  parameter logic [15:0] FIXED_ADDR = 16'h0038,
  parameter logic [15:0] NMI_ADDR   = 16'h0066,
  parameter int          FIXED_CYC  = 13,
  parameter int          TABLE_CYC  = 19,
  parameter int          NMI_CYC    = 13
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              warmRstN,
  input  ctrlStrobe_t       strobes,
  input  logic [DATA_W-1:0] irqByte,
  input  logic [2:0]        imField,
  input  logic [DATA_W-1:0] ldVecData,
  output logic              respValid,
  output logic [1:0]        respKind,
  output logic [ADDR_W-1:0] respTarget,
  output logic              pushPc,
  output logic              m1Exec,
  output logic [CYC_W-1:0]  respCycles,
  output logic              iff1,
  output logic              iff2,
  output logic [1:0]        irqMode
);

  localparam int HI_W = ADDR_W - DATA_W;

  irqMode_t          modeQ;
  logic [DATA_W-1:0] vecBaseQ;

  respKind_t         nxtKind;
  logic [ADDR_W-1:0] nxtTarget;
  logic              nxtPush;
  logic              nxtM1;
  logic [CYC_W-1:0]  nxtCycles;
  logic              nxtValid;

  // response selection
  always_comb begin
    nxtKind   = RESP_NONE;
    nxtTarget = '0;
    nxtPush   = 1'b0;
    nxtM1     = 1'b0;
    nxtCycles = '0;
    nxtValid  = strobes.takeNmi || strobes.takeIrq;
    if (strobes.takeNmi) begin
      nxtKind   = RESP_RESTART;
      nxtTarget = NMI_ADDR;
      nxtPush   = 1'b1;
      nxtCycles = CYC_W'(NMI_CYC);
    end else if (strobes.takeIrq) begin
      case (modeQ)
        MODE_FIXED: begin
          nxtKind   = RESP_RESTART;
          nxtTarget = FIXED_ADDR;
          nxtPush   = 1'b1;
          nxtCycles = CYC_W'(FIXED_CYC);
        end
        MODE_TABLE: begin
          nxtKind   = RESP_VECTOR;
          nxtTarget = {{(HI_W-DATA_W){1'b0}}, vecBaseQ, irqByte};
          nxtPush   = 1'b1;
          nxtCycles = CYC_W'(TABLE_CYC);
        end
        default: begin
          nxtKind   = RESP_OPCODE;
          nxtTarget = {{HI_W{1'b0}}, irqByte};
          nxtM1     = 1'b1;
        end
      endcase
    end
  end

  // enable flops
  always_ff @(posedge clk) begin
    if (!coldRstN || !warmRstN) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else if (strobes.takeNmi) begin
      iff1 <= 1'b0;
    end else if (strobes.takeIrq || strobes.clrBoth) begin
      iff1 <= 1'b0;
      iff2 <= 1'b0;
    end else if (strobes.setBoth) begin
      iff1 <= 1'b1;
      iff2 <= 1'b1;
    end else if (strobes.restoreEn) begin
      iff1 <= iff2;
    end
  end

  // mode and vector base survive a warm reset
  always_ff @(posedge clk) begin
    if (!coldRstN) begin
      modeQ    <= MODE_OPCODE;
      vecBaseQ <= VEC_INIT;
    end else begin
      if (strobes.loadMode) modeQ <= decodeModeField(imField);
      if (strobes.loadVec)  vecBaseQ <= ldVecData;
    end
  end

  // registered one-cycle response
  always_ff @(posedge clk) begin
    if (!coldRstN || !warmRstN) begin
      respValid  <= 1'b0;
      respKind   <= RESP_NONE;
      respTarget <= '0;
      pushPc     <= 1'b0;
      m1Exec     <= 1'b0;
      respCycles <= '0;
    end else begin
      respValid  <= nxtValid;
      respKind   <= nxtKind;
      respTarget <= nxtTarget;
      pushPc     <= nxtPush;
      m1Exec     <= nxtM1;
      respCycles <= nxtCycles;
    end
  end

  assign irqMode = modeQ;

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          ADDR_W     = 16,
  parameter int          CYC_W      = 5,
  parameter logic [7:0]  VEC_INIT   = 8'hFF,
  parameter logic [15:0] FIXED_ADDR = 16'h0038,
  parameter logic [15:0] NMI_ADDR   = 16'h0066,
  parameter int          FIXED_CYC  = 13,
  parameter int          TABLE_CYC  = 19,
  parameter int          NMI_CYC    = 13
) (
  input  logic              clk,
  input  logic              coldRstN,
  input  logic              warmRstN,
  input  logic              nmiReq,
  input  logic              irqReq,
  input  logic [DATA_W-1:0] irqByte,
  input  logic              diStrobe,
  input  logic              eiStrobe,
  input  logic              retnStrobe,
  input  logic              imStrobe,
  input  logic [2:0]        imField,
  input  logic              ldVecStrobe,
  input  logic [DATA_W-1:0] ldVecData,
  output logic              respValid,
  output logic [1:0]        respKind,
  output logic [ADDR_W-1:0] respTarget,
  output logic              pushPc,
  output logic              m1Exec,
  output logic [CYC_W-1:0]  respCycles,
  output logic              iff1,
  output logic              iff2,
  output logic [1:0]        irqMode
);

  ctrlStrobe_t strobes;

  irq_accept_control u_control (
    .nmiReq      (nmiReq),
    .irqReq      (irqReq),
    .liveEn      (iff1),
    .busy        (respValid),
    .diStrobe    (diStrobe),
    .eiStrobe    (eiStrobe),
    .retnStrobe  (retnStrobe),
    .imStrobe    (imStrobe),
    .ldVecStrobe (ldVecStrobe),
    .strobes     (strobes)
  );

  irq_accept_datapath #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .CYC_W      (CYC_W),
    .VEC_INIT   (VEC_INIT),
    .FIXED_ADDR (FIXED_ADDR),
    .NMI_ADDR   (NMI_ADDR),
    .FIXED_CYC  (FIXED_CYC),
    .TABLE_CYC  (TABLE_CYC),
    .NMI_CYC    (NMI_CYC)
  ) u_datapath (
    .clk        (clk),
    .coldRstN   (coldRstN),
    .warmRstN   (warmRstN),
    .strobes    (strobes),
    .irqByte    (irqByte),
    .imField    (imField),
    .ldVecData  (ldVecData),
    .respValid  (respValid),
    .respKind   (respKind),
    .respTarget (respTarget),
    .pushPc     (pushPc),
    .m1Exec     (m1Exec),
    .respCycles (respCycles),
    .iff1       (iff1),
    .iff2       (iff2),
    .irqMode    (irqMode)
  );

endmodule

// File: rtl/irq_accept_checker.sv
module irq_accept_checker #(
  parameter int          DATA_W   = 8,
  parameter int          ADDR_W   = 16,
  parameter int          CYC_W    = 5,
  parameter logic [15:0] NMI_ADDR = 16'h0066
) (
  input logic              clk,
  input logic              coldRstN,
  input logic              warmRstN,
  input logic              nmiReq,
  input logic              irqReq,
  input logic              diStrobe,
  input logic              eiStrobe,
  input logic              retnStrobe,
  input logic              respValid,
  input logic [1:0]        respKind,
  input logic [ADDR_W-1:0] respTarget,
  input logic              pushPc,
  input logic              m1Exec,
  input logic [CYC_W-1:0]  respCycles,
  input logic              iff1,
  input logic              iff2
);

  logic taking;
  assign taking = !respValid && (nmiReq || (irqReq && iff1));

  p_push_pulse_r13: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN)
    pushPc |=> !pushPc);

  p_m1_only_opcode_r5: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN)
    m1Exec |-> (respValid && respKind == 2'd1 && !pushPc));

  p_ignored_irq_r3: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN)
    (irqReq && !iff1 && !nmiReq && !respValid) |=> (!respValid && respCycles == '0));

  p_nmi_target_r8: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN)
    (nmiReq && !respValid) |=> (respValid && respTarget == ADDR_W'(NMI_ADDR) && !iff1));

  p_nmi_keeps_saved_r8: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN)
    (nmiReq && !respValid) |=> (iff2 == $past(iff2)));

  p_irq_clears_r4: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN)
    (irqReq && iff1 && !nmiReq && !respValid) |=> (!iff1 && !iff2));

  p_restore_r10: assert property (@(posedge clk) disable iff (!coldRstN || !warmRstN)
    (retnStrobe && !diStrobe && !eiStrobe && !taking) |=> (iff1 == $past(iff2) && iff2 == $past(iff2)));

endmodule

bind irq_accept_ctrl irq_accept_checker #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .CYC_W    (CYC_W),
  .NMI_ADDR (NMI_ADDR)
) u_checker (
  .clk        (clk),
  .coldRstN   (coldRstN),
  .warmRstN   (warmRstN),
  .nmiReq     (nmiReq),
  .irqReq     (irqReq),
  .diStrobe   (diStrobe),
  .eiStrobe   (eiStrobe),
  .retnStrobe (retnStrobe),
  .respValid  (respValid),
  .respKind   (respKind),
  .respTarget (respTarget),
  .pushPc     (pushPc),
  .m1Exec     (m1Exec),
  .respCycles (respCycles),
  .iff1       (iff1),
  .iff2       (iff2)
);

// File: tb/irq_accept_ctrl_bench.sv
module irq_accept_ctrl_bench;

  logic        clk = 1'b0;
  logic        coldRstN = 1'b0;
  logic        warmRstN = 1'b1;
  logic        nmiReq = 1'b0;
  logic        irqReq = 1'b0;
  logic [7:0]  irqByte = 8'h00;
  logic        diStrobe = 1'b0;
  logic        eiStrobe = 1'b0;
  logic        retnStrobe = 1'b0;
  logic        imStrobe = 1'b0;
  logic [2:0]  imField = 3'd0;
  logic        ldVecStrobe = 1'b0;
  logic [7:0]  ldVecData = 8'h00;

  logic        respValid;
  logic [1:0]  respKind;
  logic [15:0] respTarget;
  logic        pushPc;
  logic        m1Exec;
  logic [4:0]  respCycles;
  logic        iff1;
  logic        iff2;
  logic [1:0]  irqMode;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";
  bit armed = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_accept_ctrl u_irq_accept_ctrl (
    .clk(clk), .coldRstN(coldRstN), .warmRstN(warmRstN),
    .nmiReq(nmiReq), .irqReq(irqReq), .irqByte(irqByte),
    .diStrobe(diStrobe), .eiStrobe(eiStrobe), .retnStrobe(retnStrobe),
    .imStrobe(imStrobe), .imField(imField),
    .ldVecStrobe(ldVecStrobe), .ldVecData(ldVecData),
    .respValid(respValid), .respKind(respKind), .respTarget(respTarget),
    .pushPc(pushPc), .m1Exec(m1Exec), .respCycles(respCycles),
    .iff1(iff1), .iff2(iff2), .irqMode(irqMode)
  );

  // behavioural reference
  int mIff1 = 0, mIff2 = 0, mMode = 0, mVec = 255;
  int eValid = 0, eKind = 0, eTarget = 0, ePush = 0, eM1 = 0, eCycles = 0;

  always @(posedge clk) begin
    int wasBusy;
    wasBusy = eValid;
    if (!coldRstN || !warmRstN) begin
      mIff1 = 0; mIff2 = 0;
      if (!coldRstN) begin mMode = 0; mVec = 255; end
      eValid = 0; eKind = 0; eTarget = 0; ePush = 0; eM1 = 0; eCycles = 0;
    end else begin
      eValid = 0; eKind = 0; eTarget = 0; ePush = 0; eM1 = 0; eCycles = 0;
      if (!wasBusy && nmiReq) begin
        eValid = 1; eKind = 2; eTarget = 'h66; ePush = 1; eCycles = 13;
        mIff1 = 0;
      end else if (!wasBusy && irqReq && mIff1 == 1) begin
        eValid = 1; mIff1 = 0; mIff2 = 0;
        if (mMode == 0) begin eKind = 1; eTarget = irqByte; eM1 = 1; end
        else if (mMode == 1) begin eKind = 2; eTarget = 'h38; ePush = 1; eCycles = 13; end
        else begin eKind = 3; eTarget = mVec * 256 + irqByte; ePush = 1; eCycles = 19; end
      end else begin
        if (diStrobe) begin mIff1 = 0; mIff2 = 0; end
        else if (eiStrobe) begin mIff1 = 1; mIff2 = 1; end
        else if (retnStrobe) mIff1 = mIff2;
      end
      if (imStrobe) begin
        case (imField)
          3'd2, 3'd6: mMode = 1;
          3'd3, 3'd7: mMode = 2;
          default:    mMode = 0;
        endcase
      end
      if (ldVecStrobe) mVec = ldVecData;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !done) begin
      chk("respValid", respValid, eValid);
      chk("respKind", respKind, eKind);
      chk("respTarget", respTarget, eTarget);
      chk("pushPc", pushPc, ePush);
      chk("m1Exec", m1Exec, eM1);
      chk("respCycles", respCycles, eCycles);
      chk("iff1", iff1, mIff1);
      chk("iff2", iff2, mIff2);
      chk("irqMode", irqMode, mMode);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseEi();
    eiStrobe = 1'b1; cyc(1); eiStrobe = 1'b0;
  endtask

  task automatic setMode(input logic [2:0] f);
    imStrobe = 1'b1; imField = f; cyc(1); imStrobe = 1'b0;
  endtask

  task automatic oneIrq(input logic [7:0] b);
    irqReq = 1'b1; irqByte = b; cyc(1); irqReq = 1'b0; cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 cold reset state
    curReq = "R1";
    cyc(1); armed = 1'b1; cyc(2);
    coldRstN = 1'b1; cyc(2);
    // R3 maskable while disabled
    curReq = "R3";
    irqReq = 1'b1; irqByte = 8'h5A; cyc(3); irqReq = 1'b0; cyc(1);
    // R2 enable and disable
    curReq = "R2";
    pulseEi(); cyc(1);
    diStrobe = 1'b1; cyc(1); diStrobe = 1'b0; cyc(1);
    // R1 vector base initialised to 0xFF, seen through mode 2
    curReq = "R1";
    setMode(3'd3); pulseEi(); oneIrq(8'h21);
    // R5 mode 0
    curReq = "R5";
    setMode(3'd0); pulseEi(); oneIrq(8'hC7);
    // R6 mode 1, R4 clearing both enables
    curReq = "R6";
    setMode(3'd2); pulseEi(); oneIrq(8'hAA);
    curReq = "R4";
    cyc(1);
    // R7 mode 2 with a loaded base
    curReq = "R7";
    setMode(3'd7);
    ldVecStrobe = 1'b1; ldVecData = 8'h12; cyc(1); ldVecStrobe = 1'b0;
    pulseEi(); oneIrq(8'h34);
    // R12 load in the acceptance cycle uses the old base
    curReq = "R12";
    pulseEi();
    irqReq = 1'b1; irqByte = 8'h40; ldVecStrobe = 1'b1; ldVecData = 8'h99;
    cyc(1); irqReq = 1'b0; ldVecStrobe = 1'b0; cyc(1);
    pulseEi(); oneIrq(8'h41);
    // R11 all mode field values
    curReq = "R11";
    for (int f = 0; f < 8; f++) begin
      setMode(3'(f)); pulseEi(); oneIrq(8'(8'h10 + f));
    end
    // R8 NMI while disabled and while enabled
    curReq = "R8";
    diStrobe = 1'b1; cyc(1); diStrobe = 1'b0;
    nmiReq = 1'b1; cyc(1); nmiReq = 1'b0; cyc(2);
    pulseEi();
    nmiReq = 1'b1; cyc(1); nmiReq = 1'b0; cyc(2);
    // R10 restore
    curReq = "R10";
    retnStrobe = 1'b1; cyc(1); retnStrobe = 1'b0; cyc(1);
    // R9 simultaneous requests, maskable held until restored
    curReq = "R9";
    setMode(3'd6);
    irqReq = 1'b1; irqByte = 8'h77; nmiReq = 1'b1; cyc(3);
    nmiReq = 1'b0; cyc(2);
    retnStrobe = 1'b1; cyc(1); retnStrobe = 1'b0;
    cyc(1); irqReq = 1'b0; cyc(2);
    // R14 strobes ignored in an acceptance cycle
    curReq = "R14";
    pulseEi();
    irqReq = 1'b1; eiStrobe = 1'b1; cyc(1); irqReq = 1'b0; eiStrobe = 1'b0; cyc(2);
    pulseEi();
    nmiReq = 1'b1; diStrobe = 1'b1; cyc(1); nmiReq = 1'b0; diStrobe = 1'b0; cyc(2);
    // R13 held NMI gives alternating one-cycle responses
    curReq = "R13";
    nmiReq = 1'b1; cyc(5); nmiReq = 1'b0; cyc(2);
    // R1 warm reset keeps mode and base
    curReq = "R1";
    setMode(3'd3);
    ldVecStrobe = 1'b1; ldVecData = 8'h55; cyc(1); ldVecStrobe = 1'b0;
    pulseEi();
    warmRstN = 1'b0; cyc(2); warmRstN = 1'b1; cyc(1);
    pulseEi(); oneIrq(8'h0F);
    cyc(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule